// File: doc/BRIEF.md
# Four-Floor Lift Car Controller

This block steers a lift car serving four floors, numbered 0 to 3. Each cycle it reads a one-hot vector of floor calls and an emergency-stop input. It keeps the car position in a 2-bit register and drives three outputs: an up-motor command, a down-motor command and a door-open flag. A priority encoder reduces the call vector to one target floor. The most recent target is held, so the car still has a destination after the call lines drop.

A four-state machine has the states idle, rising, falling and halted. It compares the target with the car position and picks a direction. While the car travels, the position moves by exactly one floor per clock. When the stepped position equals the target, the machine returns to idle and the door opens at that edge. Emergency stop takes the machine to the halted state from any state. The car then stays where it is with the motors off and the door closed, until the stop input is released. After release the controller passes through idle and resumes toward the held target.

Top module: `lift_ctrl`

## Requirements
- R1: Synchronous active-high reset gives floor 0, state idle (code 0), door open and both motor outputs low.
- R2: When several call bits are set, the highest-numbered floor becomes the target; call bit i requests floor i.
- R3: In idle or travel, a target above the (stepped) floor selects rising (state code 1) at the next edge, and a target below it selects falling (state code 2).
- R4: In rising the floor increases by one at each edge, and in falling it decreases by one, unless emergency stop is high at that edge.
- R5: The edge that makes the floor equal to the target also returns the state to idle.
- R6: door_open is high exactly when the state is idle.
- R7: motor_up is high exactly in rising and motor_dn exactly in falling, so the two are never high together.
- R8: Emergency stop high at an edge forces the halted state (code 3) and freezes the floor, with both motors low and the door closed.
- R9: In halted with emergency stop low, the next edge goes to idle; travel then resumes toward the held target.
- R10: With no call bits set, the last target is kept; a car at its target stays idle and holds its floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| floor_call | input | 4 | Floor calls, bit i requests floor i |
| estop | input | 1 | Emergency stop, active high |
| car_floor | output | 2 | Current floor |
| motor_up | output | 1 | Up motor command |
| motor_dn | output | 1 | Down motor command |
| door_open | output | 1 | Door open flag |
| state_o | output | 2 | State code: 0 idle, 1 rising, 2 falling, 3 halted |

## Verification
A wrong state register shows up at the next cycle. The motor and door outputs decode the state directly, so a bad state gives a forbidden motor/door mix or the wrong state code. A bad held target or a bad position step shows up one edge later: the car_floor sequence breaks its one-floor-per-edge pattern, or it stops at the wrong floor. The bench compares every output with an independent model on every cycle, so any divergence is reported in the cycle it appears.

// File: rtl/lift_pkg.sv
package lift_pkg;
    localparam int FLOORS  = 4;
    localparam int FLOOR_W = $clog2(FLOORS);

    typedef logic [FLOOR_W-1:0] floor_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RISE  = 2'd1,
        ST_FALL  = 2'd2,
        ST_HALT  = 2'd3
    } lift_state_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic door;
    } lift_cmd_t;

    // Direction toward a target from a given floor
    function automatic lift_state_e seek(input floor_t tgt, input floor_t pos);
        if (tgt > pos)      return ST_RISE;
        else if (tgt < pos) return ST_FALL;
        else                return ST_IDLE;
    endfunction
endpackage

// File: rtl/lift_target.sv
module lift_target
    import lift_pkg::*;
#(
    parameter int N = FLOORS,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] calls,
    output logic [W-1:0] target
);
    logic [W-1:0] enc;
    logic [W-1:0] held;
    logic         any_call;

    // Highest-numbered set bit wins: later iterations override earlier ones
    always_comb begin
        enc = '0;
        for (int i = 0; i < N; i++) begin
            if (calls[i]) enc = W'(i);
        end
    end

    assign any_call = |calls;

    always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (any_call) held <= enc;
    end

    assign target = any_call ? enc : held;
endmodule

// File: rtl/lift_fsm.sv
module lift_fsm
    import lift_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        estop,
    input  floor_t      target,
    output floor_t      floor_q,
    output lift_state_e state_q
);
    floor_t      floor_d;
    lift_state_e state_d;

    always_comb begin
        floor_d = floor_q;
        state_d = state_q;
        if (estop) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = seek(target, floor_q);
                ST_RISE: begin
                    floor_d = floor_q + floor_t'(1);
                    state_d = seek(target, floor_d);
                end
                ST_FALL: begin
                    floor_d = floor_q - floor_t'(1);
                    state_d = seek(target, floor_d);
                end
                ST_HALT: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            floor_q <= '0;
            state_q <= ST_IDLE;
        end else begin
            floor_q <= floor_d;
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/lift_outdec.sv
module lift_outdec
    import lift_pkg::*;
(
    input  lift_state_e state,
    output lift_cmd_t   cmd
);
    always_comb begin
        cmd.up   = (state == ST_RISE);
        cmd.dn   = (state == ST_FALL);
        cmd.door = (state == ST_IDLE);
    end
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
    import lift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLOORS-1:0] floor_call,
    input  logic              estop,
    output logic [FLOOR_W-1:0] car_floor,
    output logic              motor_up,
    output logic              motor_dn,
    output logic              door_open,
    output logic [1:0]        state_o
);
    floor_t      target;
    floor_t      floor_q;
    lift_state_e state_q;
    lift_cmd_t   cmd;

    lift_target #(.N(FLOORS)) u_target (
        .clk    (clk),
        .rst    (rst),
        .calls  (floor_call),
        .target (target)
    );

    lift_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .estop   (estop),
        .target  (target),
        .floor_q (floor_q),
        .state_q (state_q)
    );

    lift_outdec u_dec (
        .state (state_q),
        .cmd   (cmd)
    );

    assign car_floor = floor_q;
    assign motor_up  = cmd.up;
    assign motor_dn  = cmd.dn;
    assign door_open = cmd.door;
    assign state_o   = state_q;
endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk
    import lift_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               estop,
    input logic [FLOOR_W-1:0] car_floor,
    input logic               motor_up,
    input logic               motor_dn,
    input logic               door_open,
    input logic [1:0]         state_o
);
    // R7
    motors_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(motor_up && motor_dn));

    // R6
    door_still_chk: assert property (@(posedge clk) disable iff (rst)
        door_open |-> (!motor_up && !motor_dn));

    // R8
    estop_halt_chk: assert property (@(posedge clk) disable iff (rst)
        estop |=> (state_o == 2'd3) && $stable(car_floor) && !door_open);

    // R4
    rise_step_chk: assert property (@(posedge clk) disable iff (rst)
        (motor_up && !estop) |=> car_floor == $past(car_floor) + 2'd1);

    // R4
    fall_step_chk: assert property (@(posedge clk) disable iff (rst)
        (motor_dn && !estop) |=> car_floor == $past(car_floor) - 2'd1);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3 && !estop) |=> door_open);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        door_open |=> $stable(car_floor));
endmodule

bind lift_ctrl lift_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .estop     (estop),
    .car_floor (car_floor),
    .motor_up  (motor_up),
    .motor_dn  (motor_dn),
    .door_open (door_open),
    .state_o   (state_o)
);

// File: tb/test_lift_ctrl.sv
`timescale 1ns/1ps
module test_lift_ctrl;
    logic       clk = 0;
    logic       rst;
    logic [3:0] floor_call;
    logic       estop;
    logic [1:0] car_floor;
    logic       motor_up, motor_dn, door_open;
    logic [1:0] state_o;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [1:0] m_floor, m_state, m_held;

    always #2.5 clk = ~clk;

    lift_ctrl i_lift_ctrl (
        .clk(clk), .rst(rst), .floor_call(floor_call), .estop(estop),
        .car_floor(car_floor), .motor_up(motor_up), .motor_dn(motor_dn),
        .door_open(door_open), .state_o(state_o)
    );

    function automatic logic [1:0] top_bit(input logic [3:0] c);
        logic [1:0] r = 2'd0;
        for (int i = 0; i < 4; i++) if (c[i]) r = 2'(i);
        return r;
    endfunction

    function automatic logic [1:0] dir(input logic [1:0] t, input logic [1:0] p);
        if (t > p) return 2'd1;
        if (t < p) return 2'd2;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R4/R5 floor", {2'b0, car_floor}, {2'b0, m_floor});
        chk("R3/R8/R9 state", {2'b0, state_o}, {2'b0, m_state});
        chk("R6 door", {3'b0, door_open}, {3'b0, m_state == 2'd0});
        chk("R7 up", {3'b0, motor_up}, {3'b0, m_state == 2'd1});
        chk("R7 dn", {3'b0, motor_dn}, {3'b0, m_state == 2'd2});
    endtask

    // drive one cycle, advance model, compare after the edge
    task automatic cyc(input logic [3:0] c, input logic e);
        logic [1:0] tgt, nf, ns;
        @(negedge clk);
        floor_call = c;
        estop = e;
        tgt = (c != 0) ? top_bit(c) : m_held;
        nf = m_floor;
        ns = m_state;
        if (e) ns = 2'd3;
        else case (m_state)
            2'd0: ns = dir(tgt, m_floor);
            2'd1: begin nf = m_floor + 2'd1; ns = dir(tgt, nf); end
            2'd2: begin nf = m_floor - 2'd1; ns = dir(tgt, nf); end
            default: ns = 2'd0;
        endcase
        @(posedge clk);
        #1;
        if (c != 0) m_held = top_bit(c);
        m_floor = nf;
        m_state = ns;
        compare_all();
    endtask

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        logic [3:0] c;
        seed = $urandom(32'd1234);
        rst = 1; floor_call = 0; estop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_floor = 0; m_state = 0; m_held = 0;
        // R1 reset state
        chk("R1 floor", {2'b0, car_floor}, 4'd0);
        chk("R1 state", {2'b0, state_o}, 4'd0);
        chk("R1 door", {3'b0, door_open}, 4'd1);
        chk("R1 motors", {2'b0, motor_up, motor_dn}, 4'd0);

        // R2 multi-bit call: floors 1 and 2 -> target 2; R3 rising
        cyc(4'b0110, 0);
        chk("R3 rising", {2'b0, state_o}, 4'd1);
        // R10 calls drop, target held
        cyc(4'b0000, 0);
        cyc(4'b0000, 0);
        chk("R2/R5 arrive floor 2", {2'b0, car_floor}, 4'd2);
        chk("R5 idle at arrival", {2'b0, state_o}, 4'd0);
        repeat (3) cyc(4'b0000, 0);
        chk("R10 stays", {2'b0, car_floor}, 4'd2);

        // R3 falling toward 0
        cyc(4'b0001, 0);
        chk("R3 falling", {2'b0, state_o}, 4'd2);
        cyc(4'b0000, 0);
        // R8 estop mid trip: floor frozen at 1
        cyc(4'b0000, 1);
        chk("R8 halted", {2'b0, state_o}, 4'd3);
        chk("R8 frozen", {2'b0, car_floor}, 4'd1);
        cyc(4'b1000, 1);
        chk("R8 still halted", {2'b0, state_o}, 4'd3);
        // R9 release -> idle, then resume toward floor 3
        cyc(4'b0000, 0);
        chk("R9 idle after release", {2'b0, state_o}, 4'd0);
        cyc(4'b0000, 0);
        chk("R9 resumes rising", {2'b0, state_o}, 4'd1);
        repeat (3) cyc(4'b0000, 0);
        chk("R2 top floor reached", {2'b0, car_floor}, 4'd3);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 9);
            if (r < 6) c = 4'b0000;
            else if (r < 8) c = 4'b0001 << $urandom_range(0, 3);
            else c = 4'($urandom_range(0, 15));
            cyc(c, $urandom_range(0, 19) == 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule